// File: doc/BRIEF.md
# Five-Stage XOR Feedback Sequence Generator

This block is a five-stage shift register whose leftmost stage is fed by the exclusive-OR of the third and fifth stages. Stages are numbered 1 to 5 from left to right. On every enabled clock edge the contents move one place toward stage 5. The stage-1 input is computed from the outputs as they stood before that edge. From any nonzero start word the register walks through all 31 nonzero words before it returns to where it began. A system uses the block as a cheap pseudo-random source: the 5-bit parallel word, or the serial bit taken from stage 5.

A load strobe replaces the contents with a seed and records that seed as the reference for period detection. A registered pulse marks each return of the state to that reference after shifting. A separate flag shows the all-zero word. The feedback cannot leave the all-zero word, so the register is stuck there until a nonzero seed is loaded.

A small control machine tracks the run phase:
- FRESH: entered by reset, or by loading a nonzero seed. A shift moves it to ADVANCED.
- ADVANCED: held while shifting or idle.
- STUCK: entered by loading a zero seed, and held through any shifting.
- From any phase, a nonzero load returns to FRESH and a zero load goes to STUCK.

Top module: `shift5_xor_gen`

## Requirements
- R1: `rst` high at a clock edge is synchronous and wins over every other input. After that edge `state_o` = 5'b11111, the reference seed is 5'b11111, and `wrap_o` = 0.
- R2: `state_o[4]` is stage 1 and `state_o[0]` is stage 5. On an edge with `shift_en` = 1 and `load_en` = 0, the new `state_o` is {old[2] ^ old[0], old[4:1]}.
- R3: `serial_o` always equals stage 5, which is `state_o[0]`.
- R4: On an edge with `load_en` = 1, `state_o` takes `seed_i` whatever `shift_en` is, and `wrap_o` is 0 after that edge.
- R5: On an edge with `load_en` = 0 and `shift_en` = 0, `state_o` keeps its value.
- R6: Starting from 5'b11111, 31 consecutive shifts produce 31 distinct nonzero words.
- R7: `wrap_o` is 1 for exactly the cycle after a shift edge that made `state_o` equal to the reference seed, provided that seed is nonzero. Otherwise it is 0.
- R8: `stuck_o` is 1 exactly when `state_o` is 5'b00000. Shifting from that word leaves it at 5'b00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advance the register by one stage |
| load_en | input | 1 | Load `seed_i` and record it as the reference; wins over shift |
| seed_i | input | 5 | Seed word, bit 4 = stage 1 |
| state_o | output | 5 | Parallel state, bit 0 = stage 5 |
| serial_o | output | 1 | Stage 5 output |
| stuck_o | output | 1 | All-zero lock-up indication |
| wrap_o | output | 1 | One-cycle pulse when the sequence returns to the seed |

## Verification
Load and shift can both be requested at the same edge. The hardest case is a load placed on the very edge where the thirtieth-plus-one shift would have brought the state back to its seed and raised the period pulse. The bench runs 30 shifts from a loaded seed and then drives load and shift together. It expects the new seed in the state and no pulse on that cycle. A second collision loads a zero seed while shifting is enabled, and the bench expects the lock-up flag at once.

// File: rtl/shift5_pkg.sv
package shift5_pkg;
    parameter int NSTAGE    = 5;
    parameter int TAP_STAGE = 3;

    localparam int TAP_BIT  = NSTAGE - TAP_STAGE;
    localparam int LAST_BIT = 0;

    typedef logic [NSTAGE-1:0] stage_t;

    localparam stage_t ALL_ONES = '1;

    typedef enum logic [1:0] {
        PH_FRESH    = 2'd0,
        PH_ADVANCED = 2'd1,
        PH_STUCK    = 2'd2
    } phase_t;
endpackage

// File: rtl/shift5_core.sv
module shift5_core
    import shift5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_en,
    input  logic   shift_en,
    input  stage_t seed_i,
    output stage_t cur_o,
    output stage_t shifted_o
);
    stage_t cur_q;
    logic   fb;

    always_comb begin
        fb        = cur_q[TAP_BIT] ^ cur_q[LAST_BIT];
        shifted_o = {fb, cur_q[NSTAGE-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst)           cur_q <= ALL_ONES;
        else if (load_en)  cur_q <= seed_i;
        else if (shift_en) cur_q <= shifted_o;
    end

    assign cur_o = cur_q;

    a_r1_reset_ones: assert property (@(posedge clk)
        rst |=> cur_q == ALL_ONES);

    a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cur_q == $past(seed_i));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !shift_en) |=> $stable(cur_q));

    a_r2_shift_right: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en) |=> cur_q[NSTAGE-2:0] == $past(cur_q[NSTAGE-1:1]));
endmodule

// File: rtl/shift5_ctrl.sv
module shift5_ctrl
    import shift5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_en,
    input  logic   shift_en,
    input  stage_t seed_i,
    input  stage_t cur_i,
    input  stage_t shifted_i,
    output logic   stuck_o,
    output logic   wrap_o
);
    phase_t phase_q, phase_d;
    stage_t ref_q;
    logic   wrap_q;

    always_comb begin
        phase_d = phase_q;
        if (load_en) begin
            phase_d = (seed_i == '0) ? PH_STUCK : PH_FRESH;
        end else if (shift_en) begin
            unique case (phase_q)
                PH_FRESH:    phase_d = PH_ADVANCED;
                PH_ADVANCED: phase_d = PH_ADVANCED;
                PH_STUCK:    phase_d = PH_STUCK;
                default:     phase_d = PH_FRESH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FRESH;
            ref_q   <= ALL_ONES;
        end else begin
            phase_q <= phase_d;
            if (load_en) ref_q <= seed_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load_en || !shift_en) wrap_q <= 1'b0;
        else wrap_q <= (phase_q != PH_STUCK) && (shifted_i == ref_q);
    end

    assign stuck_o = (phase_q == PH_STUCK);
    assign wrap_o  = wrap_q;

    a_r8_stuck_tracks_zero: assert property (@(posedge clk) disable iff (rst)
        stuck_o == (cur_i == '0));

    a_r8_stuck_sticky: assert property (@(posedge clk) disable iff (rst)
        (stuck_o && !load_en) |=> stuck_o);

    a_r7_wrap_single: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q);

    a_r7_wrap_not_stuck: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (!stuck_o && cur_i == ref_q));
endmodule

// File: rtl/shift5_xor_gen.sv
module shift5_xor_gen
    import shift5_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_en,
    input  logic       load_en,
    input  logic [4:0] seed_i,
    output logic [4:0] state_o,
    output logic       serial_o,
    output logic       stuck_o,
    output logic       wrap_o
);
    stage_t cur_w;
    stage_t shifted_w;

    shift5_core core_i (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .seed_i    (seed_i),
        .cur_o     (cur_w),
        .shifted_o (shifted_w)
    );

    shift5_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .seed_i    (seed_i),
        .cur_i     (cur_w),
        .shifted_i (shifted_w),
        .stuck_o   (stuck_o),
        .wrap_o    (wrap_o)
    );

    assign state_o  = cur_w;
    assign serial_o = cur_w[LAST_BIT];

    a_r3_serial_is_last: assert property (@(posedge clk) disable iff (rst)
        serial_o == state_o[0]);
endmodule

// File: tb/shift5_xor_gen_tb_top.sv
`timescale 1ns/1ps
module shift5_xor_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic       load_en = 1'b0;
    logic [4:0] seed_i = 5'd0;
    logic [4:0] state_o;
    logic       serial_o, stuck_o, wrap_o;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [4:0] st;
        logic       ser;
        logic       stk;
        logic       wrp;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic [4:0]  m_st = 5'h1F;
    logic [4:0]  m_ref = 5'h1F;
    logic [31:0] seen = '0;

    always #4 clk = ~clk;

    shift5_xor_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .load_en  (load_en),
        .seed_i   (seed_i),
        .state_o  (state_o),
        .serial_o (serial_o),
        .stuck_o  (stuck_o),
        .wrap_o   (wrap_o)
    );

    task automatic step(input logic r, input logic ld, input logic sh,
                        input logic [4:0] sd, input string tag);
        exp_t       e;
        logic [4:0] nx;
        logic       w;
        @(negedge clk);
        rst = r; load_en = ld; shift_en = sh; seed_i = sd;
        w = 1'b0;
        if (r) begin
            m_st = 5'h1F; m_ref = 5'h1F;
        end else if (ld) begin
            m_st = sd; m_ref = sd;
        end else if (sh) begin
            nx   = {m_st[2] ^ m_st[0], m_st[4:1]};
            w    = (m_ref != 5'd0) && (nx == m_ref);
            m_st = nx;
        end
        e.st = m_st; e.ser = m_st[0]; e.stk = (m_st == 5'd0); e.wrp = w; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_run++;
            if (e.tag == "R6") seen[state_o] = 1'b1;
            if (state_o !== e.st) begin
                n_fail++;
                $display("FAIL %s state_o actual=%b expected=%b", e.tag, state_o, e.st);
            end else if (serial_o !== e.ser) begin
                n_fail++;
                $display("FAIL R3 serial_o actual=%b expected=%b", serial_o, e.ser);
            end else if (stuck_o !== e.stk) begin
                n_fail++;
                $display("FAIL R8 stuck_o actual=%b expected=%b", stuck_o, e.stk);
            end else if (wrap_o !== e.wrp) begin
                n_fail++;
                $display("FAIL R7 wrap_o actual=%b expected=%b (%s)", wrap_o, e.wrp, e.tag);
            end
        end
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        step(1, 0, 0, 5'h00, "R1");
        step(1, 1, 1, 5'h05, "R1");
        // R6 / R2 / R7: one full period from all ones, pulse on the 31st shift
        for (int i = 0; i < 31; i++) step(0, 0, 1, 5'h00, "R6");
        // R5: hold with shift disabled, pulse must drop
        for (int i = 0; i < 3; i++) step(0, 0, 0, 5'h1A, "R5");
        // R4: load wins over shift
        step(0, 1, 1, 5'h16, "R4");
        for (int i = 0; i < 30; i++) step(0, 0, 1, 5'h00, "R2");
        // R4 / R7: load on the edge that would have wrapped
        step(0, 1, 1, 5'h09, "R4");
        for (int i = 0; i < 31; i++) step(0, 0, 1, 5'h00, "R7");
        step(0, 0, 0, 5'h00, "R7");
        // R8: zero seed locks up
        step(0, 1, 1, 5'h00, "R8");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 5'h00, "R8");
        step(0, 1, 0, 5'h01, "R8");
        for (int i = 0; i < 7; i++) step(0, 0, 1, 5'h00, "R2");
        // R1: reset in mid-run wins over load and shift
        step(1, 1, 1, 5'h03, "R1");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 5'h00, "R2");
        step(0, 0, 0, 5'h00, "R5");
        @(negedge clk);
        @(negedge clk);
        n_run++;
        if ($countones(seen) != 31 || seen[0]) begin
            n_fail++;
            $display("FAIL R6 distinct states actual=%0d zero_seen=%b expected=31 zero_seen=0",
                     $countones(seen), seen[0]);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule